// File: doc/BRIEF.md
# Power domain gating sequencer

This block drives the isolation and power-switch controls of one switchable power domain. Software writes a request into a control register: bit 0 asks for power-down and bit 1 asks for power-up. The block then runs a two-phase timed sequence. Power-down raises isolation, waits a first programmed count, waits a second programmed count, and then opens the switch. Power-up closes the switch, waits the two power-up counts, and then drops isolation. Each request bit reads back as 1 while its sequence runs and clears itself when the sequence ends, so software can poll for completion. A one-cycle done pulse marks the same moment.

A gating-enable bit decides whether a power-down request may actually remove power. When the bit is 0, a power-down request is accepted and completes, but it leaves the domain powered. Two delay registers each hold two 6-bit cycle counts. A count of 0 is treated as one cycle.

Top module: `pwr_gate_seq`

## Requirements
- R1: After reset, iso_en_o=0, sw_en_o=1, done_o=0 and dom_off_o=0, and every register reads 0.
- R2: Register address 0 is control: written bit 0 requests power-down, written bit 1 requests power-up. Reading it returns {power-up pending, power-down pending} in bits [1:0], with 0 elsewhere. A pending bit is 1 from the accepting edge until the completing edge.
- R3: On a power-down with gating enabled, iso_en_o rises at the accepting edge. sw_en_o falls exactly Wa+Wb edges later, where Wa is address 2 bits [5:0] and Wb is address 2 bits [13:8].
- R4: On a power-up, sw_en_o rises at the accepting edge. iso_en_o falls exactly Wa+Wb edges later, where Wa is address 3 bits [5:0] and Wb is address 3 bits [13:8].
- R5: done_o is high for exactly the one cycle that follows the completing edge. The pending bit clears at that same edge.
- R6: Address 1 bit 0 is the gating enable. When it is 0, a power-down request leaves iso_en_o and sw_en_o unchanged and completes one edge after acceptance.
- R7: If bits 0 and 1 are written together, only the power-down request is taken.
- R8: A control write while any request is pending is ignored.
- R9: A delay field of 0 counts as one cycle. A field of 63 counts as 63 cycles.
- R10: Address 1 reads back bit 0 only. Addresses 2 and 3 read back bits [5:0] and [13:8] only. All other bits read 0.
- R11: dom_off_o is 1 exactly when the switch is open (sw_en_o=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| iso_en_o | output | 1 | Isolation enable |
| sw_en_o | output | 1 | Power switch enable (1 = powered) |
| done_o | output | 1 | One-cycle sequence completion pulse |
| dom_off_o | output | 1 | Status: domain switched off |

## Verification
A sequencer stuck in the wrong phase, or a counter loaded with the wrong field, shows up as an isolation or switch edge that arrives a cycle early or late. It can also show up as a pending bit that never clears. The bench's reference model tracks the remaining cycle count for each sequence and compares all outputs, plus the control readback, after every edge. Any such fault is therefore reported in the first cycle it reaches a port. A missed acceptance or a wrongly accepted request changes the pending bits one edge after the write, so it is caught on the next cycle as well.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PD_NOP,
        ST_PD_ISO,
        ST_PD_SW,
        ST_PU_SW,
        ST_PU_ISO
    } pgs_state_e;

    localparam int unsigned A_CTRL  = 0;
    localparam int unsigned A_GATE  = 1;
    localparam int unsigned A_PDDLY = 2;
    localparam int unsigned A_PUDLY = 3;
endpackage

// File: rtl/pgs_regs.sv
module pgs_regs #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DLY_W  = 6,
    parameter int unsigned HI_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              pd_pend_i,
    input  logic              pu_pend_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ctrl_wr_o,
    output logic [1:0]        ctrl_bits_o,
    output logic              gate_o,
    output logic [DLY_W-1:0]  pd_a_o,
    output logic [DLY_W-1:0]  pd_b_o,
    output logic [DLY_W-1:0]  pu_a_o,
    output logic [DLY_W-1:0]  pu_b_o
);
    import pgs_pkg::*;

    typedef struct packed {
        logic             gate;
        logic [DLY_W-1:0] pd_a;
        logic [DLY_W-1:0] pd_b;
        logic [DLY_W-1:0] pu_a;
        logic [DLY_W-1:0] pu_b;
    } regs_t;

    regs_t r_d, r_q;
    logic  unused_wbits;

    assign unused_wbits = ^wdata_i;

    always_comb begin
        r_d = r_q;
        if (wr_i) begin
            if (addr_i == ADDR_W'(A_GATE)) begin
                r_d.gate = wdata_i[0];
            end else if (addr_i == ADDR_W'(A_PDDLY)) begin
                r_d.pd_a = wdata_i[DLY_W-1:0];
                r_d.pd_b = wdata_i[HI_LSB +: DLY_W];
            end else if (addr_i == ADDR_W'(A_PUDLY)) begin
                r_d.pu_a = wdata_i[DLY_W-1:0];
                r_d.pu_b = wdata_i[HI_LSB +: DLY_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(A_CTRL)) begin
            rdata_o[0] = pd_pend_i;
            rdata_o[1] = pu_pend_i;
        end else if (addr_i == ADDR_W'(A_GATE)) begin
            rdata_o[0] = r_q.gate;
        end else if (addr_i == ADDR_W'(A_PDDLY)) begin
            rdata_o[DLY_W-1:0]        = r_q.pd_a;
            rdata_o[HI_LSB +: DLY_W]  = r_q.pd_b;
        end else begin
            rdata_o[DLY_W-1:0]        = r_q.pu_a;
            rdata_o[HI_LSB +: DLY_W]  = r_q.pu_b;
        end
    end

    assign ctrl_wr_o   = wr_i && (addr_i == ADDR_W'(A_CTRL));
    assign ctrl_bits_o = wdata_i[1:0];
    assign gate_o      = r_q.gate;
    assign pd_a_o      = r_q.pd_a;
    assign pd_b_o      = r_q.pd_b;
    assign pu_a_o      = r_q.pu_a;
    assign pu_b_o      = r_q.pu_b;
endmodule

// File: rtl/pgs_timer.sv
module pgs_timer #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         last_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (load_i)               t_d.cnt = load_val_i;
        else if (t_q.cnt != '0)   t_d.cnt = t_q.cnt - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign last_o = (t_q.cnt == W'(1));
endmodule

// File: rtl/pgs_fsm.sv
module pgs_fsm #(
    parameter int unsigned DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr_i,
    input  logic [1:0]       ctrl_bits_i,
    input  logic             gate_i,
    input  logic [DLY_W-1:0] pd_a_i,
    input  logic [DLY_W-1:0] pd_b_i,
    input  logic [DLY_W-1:0] pu_a_i,
    input  logic [DLY_W-1:0] pu_b_i,
    input  logic             last_i,
    output logic             load_o,
    output logic [DLY_W-1:0] load_val_o,
    output logic             iso_o,
    output logic             sw_o,
    output logic             done_o,
    output logic             pd_pend_o,
    output logic             pu_pend_o
);
    import pgs_pkg::*;

    typedef struct packed {
        pgs_state_e st;
        logic       iso;
        logic       sw;
        logic       done;
        logic       pd_req;
        logic       pu_req;
    } fsm_t;

    fsm_t s_d, s_q;

    function automatic logic [DLY_W-1:0] min1(input logic [DLY_W-1:0] v);
        return (v == '0) ? DLY_W'(1) : v;
    endfunction

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        load_o     = 1'b0;
        load_val_o = '0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (ctrl_wr_i && ctrl_bits_i[0]) begin
                    s_d.pd_req = 1'b1;
                    if (gate_i) begin
                        s_d.st     = ST_PD_ISO;
                        s_d.iso    = 1'b1;
                        load_o     = 1'b1;
                        load_val_o = min1(pd_a_i);
                    end else begin
                        s_d.st = ST_PD_NOP;
                    end
                end else if (ctrl_wr_i && ctrl_bits_i[1]) begin
                    s_d.pu_req = 1'b1;
                    s_d.st     = ST_PU_SW;
                    s_d.sw     = 1'b1;
                    load_o     = 1'b1;
                    load_val_o = min1(pu_a_i);
                end
            end
            ST_PD_NOP: begin
                s_d.st     = ST_IDLE;
                s_d.pd_req = 1'b0;
                s_d.done   = 1'b1;
            end
            ST_PD_ISO: begin
                if (last_i) begin
                    s_d.st     = ST_PD_SW;
                    load_o     = 1'b1;
                    load_val_o = min1(pd_b_i);
                end
            end
            ST_PD_SW: begin
                if (last_i) begin
                    s_d.st     = ST_IDLE;
                    s_d.sw     = 1'b0;
                    s_d.pd_req = 1'b0;
                    s_d.done   = 1'b1;
                end
            end
            ST_PU_SW: begin
                if (last_i) begin
                    s_d.st     = ST_PU_ISO;
                    load_o     = 1'b1;
                    load_val_o = min1(pu_b_i);
                end
            end
            ST_PU_ISO: begin
                if (last_i) begin
                    s_d.st     = ST_IDLE;
                    s_d.iso    = 1'b0;
                    s_d.pu_req = 1'b0;
                    s_d.done   = 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.st     <= ST_IDLE;
            s_q.sw     <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign iso_o     = s_q.iso;
    assign sw_o      = s_q.sw;
    assign done_o    = s_q.done;
    assign pd_pend_o = s_q.pd_req;
    assign pu_pend_o = s_q.pu_req;
endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DLY_W  = 6,
    parameter int unsigned HI_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              iso_en_o,
    output logic              sw_en_o,
    output logic              done_o,
    output logic              dom_off_o
);
    logic             ctrl_wr;
    logic [1:0]       ctrl_bits;
    logic             gate_en;
    logic [DLY_W-1:0] pd_a, pd_b, pu_a, pu_b;
    logic             tmr_load, tmr_last;
    logic [DLY_W-1:0] tmr_val;
    logic             pd_pend, pu_pend;

    pgs_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DLY_W(DLY_W), .HI_LSB(HI_LSB)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .pd_pend_i(pd_pend), .pu_pend_i(pu_pend),
        .rdata_o(reg_rdata_o), .ctrl_wr_o(ctrl_wr), .ctrl_bits_o(ctrl_bits),
        .gate_o(gate_en), .pd_a_o(pd_a), .pd_b_o(pd_b), .pu_a_o(pu_a), .pu_b_o(pu_b)
    );

    pgs_timer #(.W(DLY_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val),
        .last_o(tmr_last)
    );

    pgs_fsm #(.DLY_W(DLY_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_wr_i(ctrl_wr), .ctrl_bits_i(ctrl_bits),
        .gate_i(gate_en), .pd_a_i(pd_a), .pd_b_i(pd_b), .pu_a_i(pu_a), .pu_b_i(pu_b),
        .last_i(tmr_last), .load_o(tmr_load), .load_val_o(tmr_val),
        .iso_o(iso_en_o), .sw_o(sw_en_o), .done_o(done_o),
        .pd_pend_o(pd_pend), .pu_pend_o(pu_pend)
    );

    assign dom_off_o = ~sw_en_o;
endmodule

// File: rtl/pwr_gate_seq_chk.sv
module pwr_gate_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic iso_en,
    input logic sw_en,
    input logic done,
    input logic pd_pend,
    input logic pu_pend
);
    AST_SW_OFF_UNDER_ISO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_en) |-> iso_en); // R3

    AST_ISO_DROP_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_en) |-> sw_en); // R4

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5

    AST_CLEAR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pd_pend) || $fell(pu_pend)) |-> done); // R5

    AST_SINGLE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pd_pend, pu_pend})); // R7
endmodule

bind pwr_gate_seq pwr_gate_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .iso_en(iso_en_o), .sw_en(sw_en_o),
    .done(done_o), .pd_pend(pd_pend), .pu_pend(pu_pend)
);

// File: tb/pwr_gate_seq_bench.sv
module pwr_gate_seq_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        iso, sw, done, doff;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    pwr_gate_seq u_pwr_gate_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .iso_en_o(iso),
        .sw_en_o(sw), .done_o(done), .dom_off_o(doff)
    );

    always #(CLK_P/2) clk = ~clk;

    // behavioural reference state
    bit m_iso = 0, m_sw = 1, m_done = 0, m_pd = 0, m_pu = 0;
    int m_rem = 0;
    int m_kind = 0; // 1 power-down, 2 power-up, 3 no-op power-down
    int m_gate = 0, m_pda = 0, m_pdb = 0, m_pua = 0, m_pub = 0;

    function automatic int w1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_iso = 0; m_sw = 1; m_done = 0; m_pd = 0; m_pu = 0; m_rem = 0;
            m_gate = 0; m_pda = 0; m_pdb = 0; m_pua = 0; m_pub = 0;
        end else begin
            m_done = 0;
            if (m_pd || m_pu) begin
                m_rem--;
                if (m_rem == 0) begin
                    if (m_kind == 1) m_sw = 0;
                    if (m_kind == 2) m_iso = 0;
                    m_pd = 0; m_pu = 0; m_done = 1;
                end
            end else if (wr && addr == 2'd0) begin
                if (wdata[0]) begin
                    m_pd = 1;
                    if (m_gate != 0) begin
                        m_iso = 1; m_kind = 1; m_rem = w1(m_pda) + w1(m_pdb);
                    end else begin
                        m_kind = 3; m_rem = 1;
                    end
                end else if (wdata[1]) begin
                    m_pu = 1; m_sw = 1; m_kind = 2; m_rem = w1(m_pua) + w1(m_pub);
                end
            end
            if (wr) begin
                case (addr)
                    2'd1: m_gate = int'(wdata[0]);
                    2'd2: begin m_pda = int'(wdata[5:0]); m_pdb = int'(wdata[13:8]); end
                    2'd3: begin m_pua = int'(wdata[5:0]); m_pub = int'(wdata[13:8]); end
                    default: ;
                endcase
            end
        end
        #(CLK_P/4);
        if (rst_n && !finished) begin
            check("R3 R4 iso_en", iso, m_iso);
            check("R3 R4 sw_en", sw, m_sw);
            check("R5 done", done, m_done);
            check("R11 dom_off", doff, !m_sw);
            if (addr == 2'd0) check("R2 ctrl readback", rdata, {m_pu, m_pd});
        end
    end

    task automatic write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; addr = 2'd0; wdata = '0;
    endtask

    task automatic read_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        check(tag, rdata, exp);
        addr = 2'd0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 iso reset", iso, 0);
        check("R1 sw reset", sw, 1);
        check("R1 done reset", done, 0);
        rst_n = 1'b1;
        read_chk(2'd0, 32'h0, "R1 ctrl reset");
        read_chk(2'd1, 32'h0, "R1 gate reset");
        read_chk(2'd2, 32'h0, "R1 pd delay reset");
        read_chk(2'd3, 32'h0, "R1 pu delay reset");

        // R10 readback masks
        write(2'd2, 32'hFFFF_C3C2);
        read_chk(2'd2, 32'h0000_0302, "R10 pd delay fields");
        write(2'd3, 32'hABCD_0504);
        read_chk(2'd3, 32'h0000_0504, "R10 pu delay fields");
        write(2'd1, 32'hFFFF_FFFF);
        read_chk(2'd1, 32'h1, "R10 gate bit");

        // R3 power-down 2+3 cycles
        write(2'd0, 32'h1);
        idle(8);
        check("R3 domain off", sw, 0);
        check("R11 status off", doff, 1);
        // R4 power-up 4+5 cycles
        write(2'd0, 32'h2);
        idle(12);
        check("R4 iso released", iso, 0);

        // R9 zero delays
        write(2'd2, 32'h0);
        write(2'd3, 32'h0);
        write(2'd0, 32'h1);
        idle(4);
        write(2'd0, 32'h2);
        idle(4);

        // R7 both bits: power-down wins
        write(2'd0, 32'h3);
        idle(4);
        check("R7 power-down taken", sw, 0);
        write(2'd0, 32'h2);
        idle(4);

        // R8 writes while busy are ignored
        write(2'd2, 32'h0000_1410);
        write(2'd0, 32'h1);
        write(2'd0, 32'h2);
        write(2'd0, 32'h3);
        idle(10);
        write(2'd0, 32'h2);
        idle(40);
        check("R8 still off after busy writes", sw, 0);
        write(2'd0, 32'h2);
        idle(4);
        check("R8 back on", sw, 1);

        // R9 maximum delays
        write(2'd2, 32'h0000_3F3F);
        write(2'd3, 32'h0000_3F3F);
        write(2'd0, 32'h1);
        idle(130);
        write(2'd0, 32'h2);
        idle(130);

        // R6 gating disabled keeps domain powered
        write(2'd1, 32'h0);
        write(2'd0, 32'h1);
        idle(3);
        check("R6 sw held on", sw, 1);
        check("R6 iso untouched", iso, 0);
        read_chk(2'd0, 32'h0, "R6 request cleared");

        idle(3);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule